// File: doc/BRIEF.md
# Programmable Interrupt Rate Timer

This block produces a periodic interrupt for a time-code controller. A host programs a 10-bit divider and a control byte through two byte-wide addresses. The block counts ticks from one of three sources: a local word-clock tick, a left/right clock tick, or a crystal tick made inside the block by dividing the system clock by 143. It raises a sticky interrupt flag once every divider-plus-one selected ticks. The flag stays set until the host pulses a clear input.

The host writes the low eight divider bits at address 0. That address cannot be read back. Address 1 is the control byte. It holds the top two divider bits, the clock-source select and the run bit, and it reads back with its reserved bits as zero.

A small state machine sequences the counter through three states:
- `ST_STOP`: the counter is idle and holds its value.
- `ST_LOAD`: the counter takes the divider value. This state lasts one cycle.
- `ST_COUNT`: the counter decrements on each selected tick.

The transitions are:
- STOP→LOAD when run is set.
- LOAD→COUNT when run is still set.
- LOAD→STOP or COUNT→STOP when run is cleared.
- COUNT→COUNT on every other cycle. On a tick with the counter at zero, this self-transition reloads the counter and raises the terminal pulse.

Top module: `irt_timer`

## Requirements
- R1: After reset the interrupt output is 0, and reading the control address returns 0x00.
- R2: The control byte at address 1 has divider bits 9:8 in bits 1:0, the clock select in bits 5:4 and run in bit 7. Bits 6 and 3:2 always read 0. Reading address 0 returns 0x00, because the low divider byte is write-only.
- R3: With run set, the interrupt flag sets on exactly the (D+1)-th selected tick after the counter loads. D is the 10-bit divider, made of the high bits from the control byte and the low byte from address 0.
- R4: Clock select 00 counts the word-clock tick input, 01 counts the LR clock tick input, and 11 counts the internal crystal tick.
- R5: The internal crystal tick occurs once every 143 system clock cycles. With source 11, the interrupt therefore repeats every 143·(D+1) cycles.
- R6: Select code 10 delivers no ticks. The counter keeps its value, and counting resumes from that value when a valid code is selected again.
- R7: While run is 0, no ticks are counted and the flag cannot set. A 0→1 change of run reloads the counter, so a full D+1 ticks are needed afterwards.
- R8: The interrupt flag stays set until the clear input is pulsed. If a clear and a terminal count fall in the same cycle, the flag stays set.
- R9: A divider write made while the timer runs does not disturb the current count. The new value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also serves as the crystal for the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe for the host register interface |
| host_addr | input | 1 | Register address: 0 = divider low byte, 1 = control |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register (combinational) |
| lx_tick | input | 1 | Single-cycle word-clock tick enable |
| lr_tick | input | 1 | Single-cycle LR clock tick enable |
| irq_clear | input | 1 | Pulse to clear the interrupt flag |
| irq | output | 1 | Sticky interrupt flag |

## Verification
A corrupted down-counter shows at `irq` as an interrupt that comes early or late. The error appears on the first terminal count after the fault, which is at most D+1 selected ticks away. A state machine stuck in STOP or LOAD shows as an interrupt that never arrives. A missed reload on a run restart shows as a first period shorter than D+1 ticks, and the bench pins that period down exactly. A fault in the prescaler shows as an interrupt spacing that is not a multiple of 143 cycles within one period. Register-decode faults show directly at `host_rdata` on the next read.

// File: rtl/irt_pkg.sv
package irt_pkg;
    localparam int DIV_W  = 10;
    localparam int LOW_W  = 8;
    localparam int HIGH_W = DIV_W - LOW_W;

    typedef enum logic [1:0] {
        SRC_LX   = 2'b00,
        SRC_LR   = 2'b01,
        SRC_NONE = 2'b10,
        SRC_XTAL = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        ST_STOP  = 2'b00,
        ST_LOAD  = 2'b01,
        ST_COUNT = 2'b10
    } tmr_state_e;
endpackage

// File: rtl/irt_prescaler.sv
module irt_prescaler #(
    parameter int RATIO = 143
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign tick_o = (phase == LAST);
endmodule

// File: rtl/irt_regs.sv
module irt_regs
    import irt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [DIV_W-1:0]  div_value,
    output src_sel_e          sel,
    output logic              run
);
    logic [LOW_W-1:0]  div_lo;
    logic [HIGH_W-1:0] div_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo <= '0;
            div_hi <= '0;
            sel    <= SRC_LX;
            run    <= 1'b0;
        end else if (wr) begin
            if (!addr) begin
                div_lo <= wdata[LOW_W-1:0];
            end else begin
                div_hi <= wdata[HIGH_W-1:0];
                sel    <= src_sel_e'(wdata[5:4]);
                run    <= wdata[7];
            end
        end
    end

    assign div_value = {div_hi, div_lo};
    assign rdata     = addr ? {run, 1'b0, sel, 2'b00, div_hi} : 8'h00;
endmodule

// File: rtl/irt_tick_mux.sv
module irt_tick_mux
    import irt_pkg::*;
(
    input  src_sel_e sel,
    input  logic     lx_tick,
    input  logic     lr_tick,
    input  logic     xtal_tick,
    output logic     tick
);
    always_comb begin
        unique case (sel)
            SRC_LX:   tick = lx_tick;
            SRC_LR:   tick = lr_tick;
            SRC_XTAL: tick = xtal_tick;
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/irt_counter.sv
module irt_counter
    import irt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] reload,
    output logic             term,
    output logic [DIV_W-1:0] count,
    output tmr_state_e       state
);
    tmr_state_e       state_n;
    logic [DIV_W-1:0] count_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_STOP;
            count <= '0;
        end else begin
            state <= state_n;
            count <= count_n;
        end
    end

    always_comb begin
        state_n = state;
        count_n = count;
        term    = 1'b0;
        unique case (state)
            ST_STOP: begin
                if (run) state_n = ST_LOAD;
            end
            ST_LOAD: begin
                count_n = reload;
                state_n = run ? ST_COUNT : ST_STOP;
            end
            ST_COUNT: begin
                if (!run) begin
                    state_n = ST_STOP;
                end else if (tick) begin
                    if (count == '0) begin
                        count_n = reload;
                        term    = 1'b1;
                    end else begin
                        count_n = count - 1'b1;
                    end
                end
            end
            default: state_n = ST_STOP;
        endcase
    end
endmodule

// File: rtl/irt_timer.sv
module irt_timer
    import irt_pkg::*;
#(
    parameter int XTAL_RATIO = 143
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       lx_tick,
    input  logic       lr_tick,
    input  logic       irq_clear,
    output logic       irq
);
    logic [DIV_W-1:0] div_value;
    logic [DIV_W-1:0] cnt_value;
    src_sel_e         sel;
    tmr_state_e       cnt_state;
    logic             run;
    logic             xtal_tick;
    logic             tick;
    logic             term;

    irt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (host_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .rdata     (host_rdata),
        .div_value (div_value),
        .sel       (sel),
        .run       (run)
    );

    irt_prescaler #(.RATIO(XTAL_RATIO)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (xtal_tick)
    );

    irt_tick_mux u_mux (
        .sel       (sel),
        .lx_tick   (lx_tick),
        .lr_tick   (lr_tick),
        .xtal_tick (xtal_tick),
        .tick      (tick)
    );

    irt_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .reload (div_value),
        .term   (term),
        .count  (cnt_value),
        .state  (cnt_state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (term)      irq <= 1'b1;
        else if (irq_clear) irq <= 1'b0;
    end
endmodule

// File: rtl/irt_timer_chk.sv
module irt_timer_chk
    import irt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_addr,
    input logic [7:0]       host_rdata,
    input logic             irq,
    input logic             irq_clear,
    input logic             term,
    input logic             run,
    input logic             xtal_tick,
    input src_sel_e         sel,
    input tmr_state_e       cnt_state,
    input logic [DIV_W-1:0] cnt_value,
    input logic [DIV_W-1:0] div_value
);
    // R8: flag holds without a clear
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);

    // R8: clear without a coincident terminal count drops the flag
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !term) |=> !irq);

    // R7: a stopped timer cannot raise the flag
    p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_state == ST_STOP && !irq) |=> !irq);

    // R6: reserved select freezes the count
    p_rsv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_state == ST_COUNT && sel == SRC_NONE) |=> $stable(cnt_value));

    // R9: terminal count reloads the divider value present at that moment
    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> (cnt_value == $past(div_value)));

    // R2: reserved control bits read zero
    p_rsv_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr |-> (host_rdata[6] == 1'b0 && host_rdata[3:2] == 2'b00));

    // R5: crystal ticks are never back to back
    p_pre_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_tick |=> !xtal_tick);
endmodule

bind irt_timer irt_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .irq        (irq),
    .irq_clear  (irq_clear),
    .term       (term),
    .run        (run),
    .xtal_tick  (xtal_tick),
    .sel        (sel),
    .cnt_state  (cnt_state),
    .cnt_value  (cnt_value),
    .div_value  (div_value)
);

// File: tb/irt_timer_bench.sv
`timescale 1ns/1ps
module irt_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_addr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       lx_tick = 1'b0;
    logic       lr_tick = 1'b0;
    logic       irq_clear = 1'b0;
    logic       irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    irt_timer u_irt_timer (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .lx_tick(lx_tick),
        .lr_tick(lr_tick), .irq_clear(irq_clear), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic pulse_clear();
        @(negedge clk); irq_clear = 1'b1;
        @(negedge clk); irq_clear = 1'b0;
    endtask

    task automatic pulse_lx(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); lx_tick = 1'b1;
            @(negedge clk); lx_tick = 1'b0;
        end
    endtask

    task automatic pulse_lr(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); lr_tick = 1'b1;
            @(negedge clk); lr_tick = 1'b0;
        end
    endtask

    function automatic logic [7:0] ctrl(input logic r, input logic [1:0] s, input logic [9:0] d);
        return {r, 1'b0, s, 2'b00, d[9:8]};
    endfunction

    task automatic setup(input logic [9:0] d, input logic [1:0] s);
        host_write(1'b1, 8'h00);
        host_write(1'b0, d[7:0]);
        host_write(1'b1, ctrl(1'b1, s, d));
        idle(3);
        pulse_clear();
    endtask

    task automatic t_reset();
        logic [7:0] r;
        check("R1 irq after reset", irq, 0);
        host_read(1'b1, r);
        check("R1 control after reset", r, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] r;
        host_write(1'b1, 8'h7F);
        host_read(1'b1, r);
        check("R2 control readback 0x7F", r, 8'h33);
        host_write(1'b0, 8'hA5);
        host_read(1'b0, r);
        check("R2 low byte write-only", r, 8'h00);
        host_write(1'b1, 8'h00);
        host_read(1'b1, r);
        check("R2 control cleared", r, 8'h00);
    endtask

    task automatic t_lx_period();
        setup(10'd3, 2'b00);
        pulse_lx(3);
        check("R3 no irq after 3 of 4 ticks", irq, 0);
        pulse_lx(1);
        check("R3 irq after 4 ticks", irq, 1);
        pulse_clear();
        pulse_lr(6);
        check("R4 LR ignored when LX selected", irq, 0);
    endtask

    task automatic t_lr_period();
        setup(10'h105, 2'b01);
        pulse_lx(300);
        check("R4 LX ignored when LR selected", irq, 0);
        pulse_lr(261);
        check("R3 no irq after 261 of 262 ticks", irq, 0);
        pulse_lr(1);
        check("R3 irq after 262 LR ticks", irq, 1);
    endtask

    task automatic t_xtal(input logic [9:0] d);
        int t0;
        int t1;
        setup(d, 2'b11);
        for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
        t0 = cyc;
        pulse_clear();
        for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
        t1 = cyc;
        check("R5 crystal interrupt spacing", t1 - t0, 143 * (int'(d) + 1));
    endtask

    task automatic t_reserved();
        setup(10'd3, 2'b00);
        pulse_lx(2);
        host_write(1'b1, ctrl(1'b1, 2'b10, 10'd3));
        pulse_lx(5);
        pulse_lr(5);
        idle(300);
        check("R6 reserved select gives no irq", irq, 0);
        host_write(1'b1, ctrl(1'b1, 2'b00, 10'd3));
        pulse_lx(1);
        check("R6 held count not yet terminal", irq, 0);
        pulse_lx(1);
        check("R6 resumes from held count", irq, 1);
    endtask

    task automatic t_stop_restart();
        setup(10'd3, 2'b00);
        pulse_lx(2);
        host_write(1'b1, ctrl(1'b0, 2'b00, 10'd3));
        pulse_lx(4);
        check("R7 stopped timer raises no irq", irq, 0);
        host_write(1'b1, ctrl(1'b1, 2'b00, 10'd3));
        idle(3);
        pulse_lx(3);
        check("R7 restart reloads full count", irq, 0);
        pulse_lx(1);
        check("R7 irq after full period", irq, 1);
    endtask

    task automatic t_sticky();
        setup(10'd0, 2'b00);
        pulse_lx(1);
        check("R8 irq set", irq, 1);
        idle(20);
        check("R8 irq sticky", irq, 1);
        @(negedge clk); lx_tick = 1'b1; irq_clear = 1'b1;
        @(negedge clk); lx_tick = 1'b0; irq_clear = 1'b0;
        check("R8 set wins over clear", irq, 1);
        pulse_clear();
        check("R8 clear drops flag", irq, 0);
    endtask

    task automatic t_live_write();
        setup(10'd1, 2'b00);
        pulse_lx(1);
        host_write(1'b0, 8'd5);
        pulse_lx(1);
        check("R9 current count not disturbed", irq, 1);
        pulse_clear();
        pulse_lx(5);
        check("R9 new divider not early", irq, 0);
        pulse_lx(1);
        check("R9 new divider after reload", irq, 1);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_readback();
        t_lx_period();
        t_lr_period();
        t_xtal(10'd0);
        t_xtal(10'd2);
        t_reserved();
        t_stop_restart();
        t_sticky();
        t_live_write();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule